// File: doc/BRIEF.md
# Associative Multicast Spike Packet Router

This block steers 40-bit spike packets from one merged input stream (traffic from six neighbouring links plus locally injected packets) to 26 outputs: twenty local core ports and six outbound links. The low 32 bits of each packet are a routing key naming the source neuron. The key is compared against a table of key/mask entries, and the first valid entry that matches supplies a multicast vector. Any subset of the outputs may be set in that vector.

A packet that matches nothing falls back to a default rule. If it came in on a link, it goes out on the opposite link. If it was injected locally, it is dropped and counted. When a chosen outbound link is not ready, the copy for that link is moved to the next link round and marked as diverted. A diverted packet that arrives is not looked up. It is passed one link further round to put it back on its path, and its mark is cleared. Software fills the table through a one-cycle write port.

The control is a two-state machine. `ST_IDLE` means no packet is held and the input is ready. `ST_SEND` means a packet and its route vector are held, waiting for their outputs. The machine has these transitions:
- idle→send: an accepted packet has a route.
- send→send: the held packet leaves and a new one is taken in the same cycle, or the held packet is still blocked.
- send→idle: the held packet leaves and no new routable packet arrives.
- idle→idle: no packet arrives, or an accepted packet is dropped.

Top module: `spike_mcast_router`

## Requirements
- R1: A packet carries its header in bits 39:32 and the key in bits 31:0. Header bit 0 (packet bit 32) is the diversion mark. `out_pkt` always has bit 32 cleared, and the copy sent on link j takes `out_emg[j]` as its bit 32.
- R2: An entry matches when it is valid and (key & mask) equals (entry key & mask). When several entries match, the lowest index wins. Invalid entries never match.
- R3: In the route vector, bits 0..19 select core ports and bit 20+j selects link j. Every selected output is offered the packet in the same cycle.
- R4: An unmatched packet from link i leaves only on link (i+3) mod 6.
- R5: An unmatched local packet is dropped. One cycle after acceptance, `unrouted_err` is high for one cycle and `drop_count` rises by one, saturating at 65535.
- R6: If a selected link j is not ready, its copy goes to link (j+1) mod 6 with `out_emg` set for that link. If the substitute is also busy, or is itself selected, the packet waits.
- R7: A packet from link k with bit 32 set skips the lookup. It leaves only on link (k+1) mod 6, with bit 32 cleared and no mark.
- R8: `out_valid` bits are raised only in the cycle when every destination is ready. While the packet waits, `in_ready` is low.
- R9: A table write is seen by lookups from the next cycle on. A write never changes the route of a packet already accepted, even one accepted in the same cycle.
- R10: One packet is accepted per cycle. Its outputs appear in the cycle after acceptance, so packets offered back to back leave on consecutive cycles.
- R11: After reset no entry is valid, `in_ready` is high, and `out_valid`, `out_emg`, `unrouted_err` and `drop_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input packet offered |
| in_ready | output | 1 | Router takes the offered packet this cycle |
| in_pkt | input | 40 | Header (39:32) and routing key (31:0) |
| in_on_link | input | 1 | 1: packet came from a link, 0: local injection |
| in_link_id | input | 3 | Arrival link number, 0..5 |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry written |
| cfg_key | input | 32 | Entry key |
| cfg_mask | input | 32 | Entry mask, 1 = bit compared |
| cfg_route | input | 26 | Entry output vector |
| cfg_valid | input | 1 | Entry valid bit |
| out_valid | output | 26 | Per-output offer, bits 0..19 cores, 20..25 links |
| out_ready | input | 26 | Per-output readiness |
| out_pkt | output | 40 | Packet presented to all outputs |
| out_emg | output | 6 | Per-link diversion mark for header bit 0 |
| unrouted_err | output | 1 | Pulse for a dropped local packet |
| drop_count | output | CNT_W | Saturating count of dropped packets |

## Verification
The bench builds the router with an 8-entry table and the default 16-bit drop counter. The small table lets a handful of writes create overlapping masks, invalid shadow entries and priority ties. The 16-bit counter can be driven into saturation within the run by a steady stream of unroutable local packets. Readiness is withheld on chosen core and link outputs, which reaches the diverted, stalled and all-or-nothing paths. A table write that lands in the same cycle as an acceptance shows that the held route is kept.

// File: rtl/router_pkg.sv
package router_pkg;
    localparam int PKT_W   = 40;
    localparam int KEY_W   = 32;
    localparam int N_CORES = 20;
    localparam int N_LINKS = 6;
    localparam int N_OUT   = N_CORES + N_LINKS;
    localparam int EMG_BIT = KEY_W;          // header bit 0

    typedef logic [N_OUT-1:0] route_t;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } rt_state_e;

    // one-hot route selecting link (k + step) mod N_LINKS
    function automatic route_t link_route(input logic [2:0] k, input int unsigned step);
        int unsigned t;
        t = (int'(k) + step) % N_LINKS;
        return route_t'(1) << (N_CORES + t);
    endfunction
endpackage

// File: rtl/mc_route_table.sv
module mc_route_table #(
    parameter int DEPTH = 1024,
    parameter int KEY_W = 32,
    parameter int OUT_W = 26,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [OUT_W-1:0] wr_route,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [OUT_W-1:0] lk_route
);
    logic [KEY_W-1:0] key_mem   [DEPTH];
    logic [KEY_W-1:0] mask_mem  [DEPTH];
    logic [OUT_W-1:0] route_mem [DEPTH];
    logic [DEPTH-1:0] vld_mem;
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   vld_mem[g] <= 1'b0;
            else if (sel) vld_mem[g] <= wr_valid;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                key_mem[g]   <= wr_key;
                mask_mem[g]  <= wr_mask;
                route_mem[g] <= wr_route;
            end
        end

        assign hit[g] = vld_mem[g] &&
                        ((lk_key & mask_mem[g]) == (key_mem[g] & mask_mem[g]));
    end

    // lowest index has priority
    always_comb begin
        lk_hit   = |hit;
        lk_route = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) lk_route = route_mem[i];
        end
    end
endmodule

// File: rtl/mc_link_steer.sv
module mc_link_steer #(
    parameter int N_CORES = 20,
    parameter int N_LINKS = 6,
    localparam int N_OUT  = N_CORES + N_LINKS
) (
    input  logic [N_OUT-1:0]   route_in,
    input  logic [N_OUT-1:0]   ready,
    output logic [N_OUT-1:0]   final_out,
    output logic [N_LINKS-1:0] emg,
    output logic               ok
);
    logic [N_LINKS-1:0] links, sub, rot;

    assign links = route_in[N_OUT-1:N_CORES];

    for (genvar j = 0; j < N_LINKS; j++) begin : g_link
        assign sub[j]                   = links[j] & ~ready[N_CORES+j];
        assign rot[(j + 1) % N_LINKS]   = sub[j];
    end

    always_comb begin
        final_out = {(links & ~sub) | rot, route_in[N_CORES-1:0]};
        emg       = rot;
        ok        = ~|(rot & links) && ((final_out & ~ready) == '0);
    end
endmodule

// File: rtl/spike_mcast_router.sv
module spike_mcast_router
    import router_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [39:0]        in_pkt,
    input  logic               in_on_link,
    input  logic [2:0]         in_link_id,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [31:0]        cfg_key,
    input  logic [31:0]        cfg_mask,
    input  logic [25:0]        cfg_route,
    input  logic               cfg_valid,
    output logic [25:0]        out_valid,
    input  logic [25:0]        out_ready,
    output logic [39:0]        out_pkt,
    output logic [5:0]         out_emg,
    output logic               unrouted_err,
    output logic [CNT_W-1:0]   drop_count
);
    rt_state_e           state_q, state_d;
    logic [PKT_W-1:0]    pkt_q;
    route_t              route_q, route_d;
    logic                tbl_hit;
    route_t              tbl_route;
    route_t              steer_final;
    logic [N_LINKS-1:0]  steer_emg;
    logic                steer_ok;
    logic                accept, fire, drop, load;
    logic                err_q;
    logic [CNT_W-1:0]    cnt_q;

    mc_route_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .OUT_W(N_OUT)) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_key(cfg_key), .wr_mask(cfg_mask),
        .wr_route(cfg_route), .wr_valid(cfg_valid),
        .lk_key(in_pkt[KEY_W-1:0]), .lk_hit(tbl_hit), .lk_route(tbl_route)
    );

    mc_link_steer #(.N_CORES(N_CORES), .N_LINKS(N_LINKS)) i_steer (
        .route_in(route_q), .ready(out_ready),
        .final_out(steer_final), .emg(steer_emg), .ok(steer_ok)
    );

    // route decision for the offered packet
    always_comb begin
        route_d = '0;
        drop    = 1'b0;
        if (in_on_link && in_pkt[EMG_BIT]) route_d = link_route(in_link_id, 1);
        else if (tbl_hit)                  route_d = tbl_route;
        else if (in_on_link)               route_d = link_route(in_link_id, 3);
        else                               drop    = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        fire     = (state_q == ST_SEND) && steer_ok;
        in_ready = (state_q == ST_IDLE) || fire;
        accept   = in_valid && in_ready;
        load     = accept && !drop;
        unique case (state_q)
            ST_IDLE: state_d = load ? ST_SEND : ST_IDLE;
            ST_SEND: state_d = (load || !fire) ? ST_SEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        out_valid = fire ? steer_final : '0;
        out_emg   = fire ? steer_emg   : '0;
        out_pkt   = pkt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q   <= '0;
            route_q <= '0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (load) begin
                pkt_q          <= in_pkt;
                pkt_q[EMG_BIT] <= 1'b0;
                route_q        <= route_d;
            end
            err_q <= accept && drop;
            if (accept && drop && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign unrouted_err = err_q;
    assign drop_count   = cnt_q;
endmodule

// File: rtl/spike_router_checker.sv
module spike_router_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [25:0]      out_valid,
    input logic [25:0]      out_ready,
    input logic [39:0]      out_pkt,
    input logic [5:0]       out_emg,
    input logic             unrouted_err,
    input logic [CNT_W-1:0] drop_count
);
    assert_fire_all_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> ((out_valid & ~out_ready) == 26'd0));

    assert_mark_on_used_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_emg) |-> ((out_emg & ~out_valid[25:20]) == 6'd0));

    assert_mark_bit_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (out_pkt[32] == 1'b0));

    assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unrouted_err |-> ((drop_count == CNT_W'($past(drop_count) + 1'b1)) || (&$past(drop_count))));

    assert_drop_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count >= $past(drop_count));
endmodule

bind spike_mcast_router spike_router_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_pkt(out_pkt), .out_emg(out_emg), .unrouted_err(unrouted_err),
    .drop_count(drop_count)
);

// File: tb/test_spike_mcast_router.sv
`timescale 1ns/1ps
module test_spike_mcast_router;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;
    localparam logic [25:0] RT_A = 26'h0400088;  // cores 3,7 + link 2
    localparam logic [25:0] RT_C = 26'h0000200;  // core 9

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, in_on_link = 1'b0;
    logic [39:0] in_pkt = '0;
    logic [2:0] in_link_id = '0;
    logic cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0] cfg_key = '0, cfg_mask = '0;
    logic [25:0] cfg_route = '0;
    logic [25:0] out_valid, out_ready = '1;
    logic [39:0] out_pkt;
    logic [5:0] out_emg;
    logic unrouted_err;
    logic [15:0] drop_count;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spike_mcast_router #(.DEPTH(DEPTH), .CNT_W(16)) i_spike_mcast_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pkt(in_pkt), .in_on_link(in_on_link), .in_link_id(in_link_id),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_key(cfg_key), .cfg_mask(cfg_mask),
        .cfg_route(cfg_route), .cfg_valid(cfg_valid), .out_valid(out_valid),
        .out_ready(out_ready), .out_pkt(out_pkt), .out_emg(out_emg),
        .unrouted_err(unrouted_err), .drop_count(drop_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [39:0] p, input logic onl, input logic [2:0] id);
        @(negedge clk);
        in_pkt = p; in_on_link = onl; in_link_id = id; in_valid = 1'b1;
        @(posedge clk); #1 in_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] k, input logic [31:0] m,
                      input logic [25:0] r, input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_key = k; cfg_mask = m;
        cfg_route = r; cfg_valid = v;
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 in_ready", 64'(in_ready), 64'd1);
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 out_emg", 64'(out_emg), 64'd0);
        chk("R11 drop_count", 64'(drop_count), 64'd0);
        chk("R11 unrouted_err", 64'(unrouted_err), 64'd0);
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);   // empty table: dropped
        @(negedge clk);
        chk("R11 empty table drops", 64'(unrouted_err), 64'd1);
    endtask

    task automatic t_program;
        wr(2, 32'h00AB1200, 32'hFFFFFF00, RT_A, 1'b1);
        wr(5, 32'h00AB1200, 32'hFFFFFF00, 26'h1, 1'b1);
        wr(1, 32'h00CD0000, 32'hFFFF0000, 26'h2, 1'b0);
        wr(6, 32'h00CD0000, 32'hFFFF0000, RT_C, 1'b1);
    endtask

    task automatic t_match;
        put({8'h40, 32'h00AB12FE}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R2 lowest index wins / R3 multicast", 64'(out_valid), 64'(RT_A));
        chk("R1 out_pkt", 64'(out_pkt), 64'h4000AB12FE);
        chk("R3 no mark", 64'(out_emg), 64'd0);
        put({8'h40, 32'h00CD7777}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R2 invalid entry skipped", 64'(out_valid), 64'(RT_C));
    endtask

    task automatic t_default;
        put({8'h40, 32'h11110000}, 1'b1, 3'd1);
        @(negedge clk);
        chk("R4 link1 to link4", 64'(out_valid), 64'(26'd1 << 24));
        put({8'h40, 32'h11110000}, 1'b1, 3'd4);
        @(negedge clk);
        chk("R4 link4 to link1", 64'(out_valid), 64'(26'd1 << 21));
    endtask

    task automatic t_drop;
        put({8'h40, 32'h11110000}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R5 err pulse", 64'(unrouted_err), 64'd1);
        chk("R5 count", 64'(drop_count), 64'd2);
        chk("R5 nothing sent", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R5 pulse ends", 64'(unrouted_err), 64'd0);
    endtask

    task automatic t_realign;
        put({8'h41, 32'h00AB1200}, 1'b1, 3'd4);
        @(negedge clk);
        chk("R7 realign link5", 64'(out_valid), 64'(26'd1 << 25));
        chk("R7 mark cleared", 64'(out_pkt), 64'h4000AB1200);
        chk("R7 no new mark", 64'(out_emg), 64'd0);
        put({8'h41, 32'h11110000}, 1'b1, 3'd5);
        @(negedge clk);
        chk("R7 link5 wraps to link0", 64'(out_valid), 64'(26'd1 << 20));
    endtask

    task automatic t_emergency;
        out_ready[22] = 1'b0;
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R6 diverted to link3", 64'(out_valid), 64'h0800088);
        chk("R6 mark on link3", 64'(out_emg), 64'h08);
        out_ready[23] = 1'b0;
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R6 both busy stalls", 64'(out_valid), 64'd0);
        chk("R6 input held", 64'(in_ready), 64'd0);
        out_ready[23] = 1'b1;
        #1;
        chk("R6 substitute free", 64'(out_valid), 64'h0800088);
        @(posedge clk); #1 out_ready = '1;
    endtask

    task automatic t_allornone;
        out_ready[7] = 1'b0;
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R8 partial ready holds", 64'(out_valid), 64'd0);
            chk("R8 in_ready low", 64'(in_ready), 64'd0);
        end
        out_ready[7] = 1'b1;
        #1;
        chk("R8 all ready fires", 64'(out_valid), 64'(RT_A));
        @(posedge clk); #1;
    endtask

    task automatic t_cfg;
        out_ready[3] = 1'b0;
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        wr(2, 32'h00AB1200, 32'hFFFFFF00, 26'h1000, 1'b1);
        out_ready[3] = 1'b1;
        #1;
        chk("R9 held route kept", 64'(out_valid), 64'(RT_A));
        @(posedge clk); #1;
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R9 new route seen", 64'(out_valid), 64'h1000);
        // write and accept in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd2; cfg_key = 32'h00AB1200;
        cfg_mask = 32'hFFFFFF00; cfg_route = 26'h2000; cfg_valid = 1'b1;
        in_pkt = {8'h40, 32'h00AB1200}; in_on_link = 1'b0; in_valid = 1'b1;
        @(posedge clk); #1 cfg_we = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R9 same-cycle write not applied", 64'(out_valid), 64'h1000);
        put({8'h40, 32'h00AB1200}, 1'b0, 3'd0);
        @(negedge clk);
        chk("R9 write applied next", 64'(out_valid), 64'h2000);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        in_pkt = {8'h40, 32'h00CD0001}; in_on_link = 1'b0; in_valid = 1'b1;
        @(posedge clk); #1;
        in_pkt = {8'h40, 32'h22220000}; in_on_link = 1'b1; in_link_id = 3'd2;
        @(negedge clk);
        chk("R10 first packet", 64'(out_valid), 64'(RT_C));
        chk("R10 ready while sending", 64'(in_ready), 64'd1);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R10 second packet next cycle", 64'(out_valid), 64'(26'd1 << 25));
        chk("R10 second payload", 64'(out_pkt), 64'h4022220000);
    endtask

    task automatic t_sat;
        @(negedge clk);
        in_pkt = {8'h40, 32'h33330000}; in_on_link = 1'b0; in_valid = 1'b1;
        repeat (65540) @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R5 counter saturates", 64'(drop_count), 64'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_match;
        t_default;
        t_drop;
        t_realign;
        t_emergency;
        t_allornone;
        t_cfg;
        t_b2b;
        t_sat;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule